// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block sits between instruction fetch and the execute stage of a small two-slot VLIW-style core. It accepts one 32-bit fetched word at a time. The two top bits of the word choose how the word is split and issued. A word holds either one long operation or a pair of 15-bit short operations. A pair is issued right slot first, left slot first, or as a parallel packet. For each slot the block sends the execute stage a one-cycle issue strobe. The strobe carries a slot tag, a role code, an opcode-class index taken from fixed bit fields, and the raw operation bits. The block then waits for the execute stage to answer with a done pulse.

The done pulse comes with two flags. One reports whether the issued operation changed the program counter. The other gives the result of a condition-test operation. In sequential pairs, a PC change cancels the second slot. In a parallel packet that contains a condition-test slot, the test runs first, and the other slot runs only when the test result is true. A class with no legal entry raises an illegal-instruction trap pulse instead of an issue, and the rest of the packet is dropped. Four saturating statistics counters keep totals for cycles, skipped second slots, and true and false condition outcomes.

Top module: `dual_slot_issuer`

## Requirements
- R1: Format 2'b00 in bits 31:30 issues exactly one slot with tag LONG (0) and role LONG (0). Its class is word bits 29:24 and its operation bits are word bits 29:0.
- R2: Format 2'b01 issues the right short (bits 14:0, tag RIGHT = 2) with role SEQ_FIRST (1), then the left short (bits 29:15, tag LEFT = 1) with role SEQ_SECOND (2). A short's class is bits 14:9 of its 15-bit slot, and its operation bits are the slot zero-extended to 30 bits.
- R3: Format 2'b10 issues the left short first (role SEQ_FIRST), then the right short (role SEQ_SECOND).
- R4: In a sequential pair, if pcChanged is high on the done pulse of the first slot, the second slot is not issued, the skip counter rises by one, and wordReady returns.
- R5: In format 2'b11, a short whose class is a condition-test class (61 or 62 by default) is issued first with role COND_TEST (5); the left slot wins if both qualify. The other slot is issued with role COND_EXEC (6) only if condTrue is high on the test's done pulse. The true or false counter rises by one to match the outcome.
- R6: In format 2'b11 with no condition-test slot, the left short is issued with role PAR_LEFT (3) and then the right short with role PAR_RIGHT (4); pcChanged has no effect.
- R7: A slot whose class is illegal (63 by default, for long and short) gives a one-cycle illegalTrap in place of its issue strobe, and no later slot of that word is issued. In a parallel packet both slots are checked before anything is issued.
- R8: The cycle counter rises by one for each accepted word and by one more when the second slot of a sequential pair is issued.
- R9: issueStrobe is high for exactly one cycle per slot, and the next slot waits for execDone. wordReady is high only when no word is in progress, and a word offered while wordReady is low is ignored.
- R10: All counters are CNT_W bits wide, clear on synchronous reset and hold at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wordValid | input | 1 | Fetched word offered |
| wordIn | input | 32 | Fetched instruction word |
| wordReady | output | 1 | Sequencer idle; word taken when wordValid is high |
| issueStrobe | output | 1 | One-cycle issue of a slot |
| issueTag | output | 2 | Slot tag: 0 LONG, 1 LEFT, 2 RIGHT |
| issueRole | output | 3 | Role code of the issued slot (see R1 to R6) |
| issueClass | output | 6 | Opcode-class index of the issued slot |
| issueOp | output | 30 | Operation bits of the issued slot |
| illegalTrap | output | 1 | One-cycle illegal-instruction trap |
| execDone | input | 1 | Execute stage finished the issued slot |
| pcChanged | input | 1 | Finished slot changed the program counter |
| condTrue | input | 1 | Result of a finished condition-test slot |
| cycleCount | output | CNT_W | Cycle statistics |
| skipCount | output | CNT_W | Second slots skipped after a PC change |
| condTrueCount | output | CNT_W | Condition tests that were true |
| condFalseCount | output | CNT_W | Condition tests that were false |

## Verification
The hardest cases to reach are the ones where the sequencer's path depends on what the execute stage answers, not on the word itself. These are second-slot suppression after a PC change and the true or false branch of a condition-test packet. To reach them, a responder echoes a done pulse one cycle after each issue and drives per-packet pcChanged and condTrue values. It also holds pcChanged high during parallel packets to show that the flag is ignored there. A word is offered for one cycle while the sequencer is busy to show that it is dropped. A second instance with 3-bit counters is driven past its maximum.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int unsigned CLS_W   = 6;
  localparam int unsigned OP_W    = 30;
  localparam int unsigned SHORT_W = 15;
  localparam int unsigned CNT_NUM = 4;
  localparam int unsigned CNT_CYC   = 0;
  localparam int unsigned CNT_SKIP  = 1;
  localparam int unsigned CNT_TRUE  = 2;
  localparam int unsigned CNT_FALSE = 3;

  typedef enum logic [1:0] {FMT_LONG = 2'b00, FMT_RFIRST = 2'b01,
                            FMT_LFIRST = 2'b10, FMT_PAR = 2'b11} fmt_e;
  typedef enum logic [1:0] {TAG_LONG = 2'd0, TAG_LEFT = 2'd1, TAG_RIGHT = 2'd2} slot_tag_e;
  typedef enum logic [2:0] {ROLE_LONG = 3'd0, ROLE_SEQ_FIRST = 3'd1, ROLE_SEQ_SECOND = 3'd2,
                            ROLE_PAR_LEFT = 3'd3, ROLE_PAR_RIGHT = 3'd4,
                            ROLE_COND_TEST = 3'd5, ROLE_COND_EXEC = 3'd6} role_e;

  typedef struct packed {
    fmt_e fmt;
    logic legalLong;
    logic legalLeft;
    logic legalRight;
    logic testLeft;
    logic testRight;
  } dec_s;

  typedef struct packed {
    logic      load;
    logic      incCycle;
    logic      incSkip;
    logic      incTrue;
    logic      incFalse;
    slot_tag_e selTag;
  } ctl_s;
endpackage

// File: rtl/dsi_datapath.sv
module dsi_datapath
  import dsi_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter logic [63:0] LONG_LEGAL  = {1'b0, {63{1'b1}}},
  parameter logic [63:0] SHORT_LEGAL = {1'b0, {63{1'b1}}},
  parameter logic [63:0] TEST_MAP    = 64'h6000_0000_0000_0000
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [31:0]                     wordIn,
  input  ctl_s                            ctl,
  output dec_s                            dec,
  output logic [CLS_W-1:0]                slotClass,
  output logic [OP_W-1:0]                 slotOp,
  output logic [CNT_NUM-1:0][CNT_W-1:0]   cnt
);
  logic [31:0]        wordReg;
  logic [SHORT_W-1:0] leftSlot, rightSlot;
  logic [CLS_W-1:0]   clsLong, clsLeft, clsRight;
  logic [CNT_NUM-1:0] incVec;

  always_ff @(posedge clk) begin
    if (rst)           wordReg <= '0;
    else if (ctl.load) wordReg <= wordIn;
  end

  assign leftSlot  = wordReg[29:15];
  assign rightSlot = wordReg[14:0];
  assign clsLong   = wordReg[29:24];
  assign clsLeft   = leftSlot[14:9];
  assign clsRight  = rightSlot[14:9];

  always_comb begin
    dec.fmt        = fmt_e'(wordReg[31:30]);
    dec.legalLong  = LONG_LEGAL[clsLong];
    dec.legalLeft  = SHORT_LEGAL[clsLeft];
    dec.legalRight = SHORT_LEGAL[clsRight];
    dec.testLeft   = TEST_MAP[clsLeft];
    dec.testRight  = TEST_MAP[clsRight];
  end

  always_comb begin
    case (ctl.selTag)
      TAG_LEFT: begin
        slotClass = clsLeft;
        slotOp    = {{(OP_W-SHORT_W){1'b0}}, leftSlot};
      end
      TAG_RIGHT: begin
        slotClass = clsRight;
        slotOp    = {{(OP_W-SHORT_W){1'b0}}, rightSlot};
      end
      default: begin
        slotClass = clsLong;
        slotOp    = wordReg[29:0];
      end
    endcase
  end

  always_comb begin
    incVec            = '0;
    incVec[CNT_CYC]   = ctl.incCycle;
    incVec[CNT_SKIP]  = ctl.incSkip;
    incVec[CNT_TRUE]  = ctl.incTrue;
    incVec[CNT_FALSE] = ctl.incFalse;
  end

  for (genvar g = 0; g < CNT_NUM; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                                cnt[g] <= '0;
      else if (incVec[g] && (cnt[g] != '1))   cnt[g] <= cnt[g] + 1'b1;
    end

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt[g] == $past(cnt[g])) || (cnt[g] == $past(cnt[g]) + 1'b1));
    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(cnt[g]) == {CNT_W{1'b1}}) |-> (cnt[g] == {CNT_W{1'b1}}));
  end
endmodule

// File: rtl/dsi_control.sv
module dsi_control
  import dsi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wordValid,
  input  dec_s      dec,
  input  logic      execDone,
  input  logic      pcChanged,
  input  logic      condTrue,
  output logic      wordReady,
  output logic      issueStrobe,
  output slot_tag_e issueTag,
  output role_e     issueRole,
  output logic      illegalTrap,
  output ctl_s      ctl
);
  typedef enum logic [2:0] {ST_IDLE, ST_FIRST, ST_WAIT1, ST_SECOND, ST_WAIT2} state_e;

  state_e    state, stateNext;
  slot_tag_e firstTag, secondTag;
  role_e     firstRole, secondRole;
  logic      firstLegal, secondLegal, isSeq, isCond, phase2, doneFirst;

  always_comb begin
    firstTag    = TAG_LONG;
    secondTag   = TAG_LONG;
    firstRole   = ROLE_LONG;
    secondRole  = ROLE_LONG;
    firstLegal  = dec.legalLong;
    secondLegal = 1'b0;
    isSeq       = 1'b0;
    isCond      = 1'b0;
    case (dec.fmt)
      FMT_RFIRST: begin
        isSeq = 1'b1;
        firstTag = TAG_RIGHT; firstRole = ROLE_SEQ_FIRST;  firstLegal  = dec.legalRight;
        secondTag = TAG_LEFT; secondRole = ROLE_SEQ_SECOND; secondLegal = dec.legalLeft;
      end
      FMT_LFIRST: begin
        isSeq = 1'b1;
        firstTag = TAG_LEFT;   firstRole = ROLE_SEQ_FIRST;  firstLegal  = dec.legalLeft;
        secondTag = TAG_RIGHT; secondRole = ROLE_SEQ_SECOND; secondLegal = dec.legalRight;
      end
      FMT_PAR: begin
        firstLegal  = dec.legalLeft && dec.legalRight;
        secondLegal = 1'b1;
        isCond      = dec.testLeft || dec.testRight;
        if (dec.testLeft) begin
          firstTag = TAG_LEFT;   firstRole = ROLE_COND_TEST;
          secondTag = TAG_RIGHT; secondRole = ROLE_COND_EXEC;
        end else if (dec.testRight) begin
          firstTag = TAG_RIGHT;  firstRole = ROLE_COND_TEST;
          secondTag = TAG_LEFT;  secondRole = ROLE_COND_EXEC;
        end else begin
          firstTag = TAG_LEFT;   firstRole = ROLE_PAR_LEFT;
          secondTag = TAG_RIGHT; secondRole = ROLE_PAR_RIGHT;
        end
      end
      default: ;
    endcase
  end

  assign phase2      = (state == ST_SECOND) || (state == ST_WAIT2);
  assign doneFirst   = (state == ST_WAIT1) && execDone;
  assign wordReady   = (state == ST_IDLE);
  assign issueTag    = phase2 ? secondTag : firstTag;
  assign issueRole   = phase2 ? secondRole : firstRole;
  assign issueStrobe = ((state == ST_FIRST) && firstLegal) || ((state == ST_SECOND) && secondLegal);
  assign illegalTrap = ((state == ST_FIRST) && !firstLegal) || ((state == ST_SECOND) && !secondLegal);

  always_comb begin
    ctl.load     = wordReady && wordValid;
    ctl.incCycle = ctl.load || ((state == ST_SECOND) && secondLegal && isSeq);
    ctl.incSkip  = doneFirst && isSeq && pcChanged;
    ctl.incTrue  = doneFirst && isCond && condTrue;
    ctl.incFalse = doneFirst && isCond && !condTrue;
    ctl.selTag   = issueTag;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (wordValid) stateNext = ST_FIRST;
      ST_FIRST:  stateNext = firstLegal ? ST_WAIT1 : ST_IDLE;
      ST_WAIT1:
        if (execDone) begin
          if (dec.fmt == FMT_LONG)          stateNext = ST_IDLE;
          else if (isSeq && pcChanged)      stateNext = ST_IDLE;
          else if (isCond && !condTrue)     stateNext = ST_IDLE;
          else                              stateNext = ST_SECOND;
        end
      ST_SECOND: stateNext = secondLegal ? ST_WAIT2 : ST_IDLE;
      ST_WAIT2:  if (execDone) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R9
  issue_gap_chk: assert property (@(posedge clk) disable iff (rst)
    issueStrobe |=> !issueStrobe);
  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wordValid && wordReady) |=> !wordReady);
  // R7
  trap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    illegalTrap |=> (wordReady && !issueStrobe));
  // R4
  skip_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (doneFirst && isSeq && pcChanged) |=> (wordReady && !issueStrobe));
endmodule

// File: rtl/dual_slot_issuer.sv
module dual_slot_issuer
  import dsi_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter logic [63:0] LONG_LEGAL  = {1'b0, {63{1'b1}}},
  parameter logic [63:0] SHORT_LEGAL = {1'b0, {63{1'b1}}},
  parameter logic [63:0] TEST_MAP    = 64'h6000_0000_0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wordValid,
  input  logic [31:0]      wordIn,
  output logic             wordReady,
  output logic             issueStrobe,
  output logic [1:0]       issueTag,
  output logic [2:0]       issueRole,
  output logic [5:0]       issueClass,
  output logic [29:0]      issueOp,
  output logic             illegalTrap,
  input  logic             execDone,
  input  logic             pcChanged,
  input  logic             condTrue,
  output logic [CNT_W-1:0] cycleCount,
  output logic [CNT_W-1:0] skipCount,
  output logic [CNT_W-1:0] condTrueCount,
  output logic [CNT_W-1:0] condFalseCount
);
  dec_s      dec;
  ctl_s      ctl;
  slot_tag_e tagInt;
  role_e     roleInt;
  logic [CNT_NUM-1:0][CNT_W-1:0] cntAll;

  dsi_control ctrl_i (
    .clk(clk), .rst(rst), .wordValid(wordValid), .dec(dec),
    .execDone(execDone), .pcChanged(pcChanged), .condTrue(condTrue),
    .wordReady(wordReady), .issueStrobe(issueStrobe), .issueTag(tagInt),
    .issueRole(roleInt), .illegalTrap(illegalTrap), .ctl(ctl)
  );

  dsi_datapath #(
    .CNT_W(CNT_W), .LONG_LEGAL(LONG_LEGAL), .SHORT_LEGAL(SHORT_LEGAL), .TEST_MAP(TEST_MAP)
  ) dp_i (
    .clk(clk), .rst(rst), .wordIn(wordIn), .ctl(ctl), .dec(dec),
    .slotClass(issueClass), .slotOp(issueOp), .cnt(cntAll)
  );

  assign issueTag       = tagInt;
  assign issueRole      = roleInt;
  assign cycleCount     = cntAll[CNT_CYC];
  assign skipCount      = cntAll[CNT_SKIP];
  assign condTrueCount  = cntAll[CNT_TRUE];
  assign condFalseCount = cntAll[CNT_FALSE];
endmodule

// File: tb/dual_slot_issuer_tb_top.sv
module dual_slot_issuer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wordValid = 1'b0;
  logic [31:0] wordIn = '0;
  logic execDone = 1'b0, pcChanged = 1'b0, condTrue = 1'b0;
  logic wordReady, issueStrobe, illegalTrap;
  logic [1:0] issueTag;
  logic [2:0] issueRole;
  logic [5:0] issueClass;
  logic [29:0] issueOp;
  logic [31:0] cycleCount, skipCount, condTrueCount, condFalseCount;
  logic sReady, sStrobe, sTrap;
  logic [1:0] sTag;
  logic [2:0] sRole;
  logic [5:0] sClass;
  logic [29:0] sOp;
  logic [2:0] sCyc, sSkip, sTrue, sFalse;

  always #2 clk = ~clk;

  dual_slot_issuer dut_i (
    .clk(clk), .rst(rst), .wordValid(wordValid), .wordIn(wordIn), .wordReady(wordReady),
    .issueStrobe(issueStrobe), .issueTag(issueTag), .issueRole(issueRole),
    .issueClass(issueClass), .issueOp(issueOp), .illegalTrap(illegalTrap),
    .execDone(execDone), .pcChanged(pcChanged), .condTrue(condTrue),
    .cycleCount(cycleCount), .skipCount(skipCount),
    .condTrueCount(condTrueCount), .condFalseCount(condFalseCount));

  dual_slot_issuer #(.CNT_W(3)) dutSat_i (
    .clk(clk), .rst(rst), .wordValid(wordValid), .wordIn(wordIn), .wordReady(sReady),
    .issueStrobe(sStrobe), .issueTag(sTag), .issueRole(sRole),
    .issueClass(sClass), .issueOp(sOp), .illegalTrap(sTrap),
    .execDone(execDone), .pcChanged(pcChanged), .condTrue(condTrue),
    .cycleCount(sCyc), .skipCount(sSkip), .condTrueCount(sTrue), .condFalseCount(sFalse));

  typedef struct {
    bit          isTrap;
    logic [1:0]  tag;
    logic [2:0]  role;
    logic [5:0]  cls;
    logic [29:0] op;
    string       req;
  } exp_t;

  exp_t expQ[$];
  int checks = 0, errors = 0;
  int expCyc = 0, expSkip = 0, expTrue = 0, expFalse = 0;
  bit respPc = 0, respCond = 0, pendDone = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Responder: one done pulse, one cycle after each issue
  always @(negedge clk) begin
    execDone = 1'b0;
    pcChanged = respPc;
    condTrue = respCond;
    if (rst) pendDone = 0;
    else if (pendDone) begin execDone = 1'b1; pendDone = 0; end
    else if (issueStrobe) pendDone = 1;
  end

  // Monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && (issueStrobe || illegalTrap)) begin
      if (expQ.size() == 0) chk("R9", "unexpected slot", {issueStrobe, illegalTrap}, 0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        if (e.isTrap) chk(e.req, "trap", {illegalTrap, issueStrobe}, 2'b10);
        else chk(e.req, "issue {trap,tag,role,cls,op}",
                 {illegalTrap, issueTag, issueRole, issueClass, issueOp},
                 {1'b0, e.tag, e.role, e.cls, e.op});
      end
    end
  end

  task automatic pushIss(input string req, input logic [1:0] tag, input logic [2:0] role,
                         input logic [5:0] cls, input logic [29:0] op);
    exp_t e;
    e.isTrap = 0; e.tag = tag; e.role = role; e.cls = cls; e.op = op; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic pushTrap(input string req);
    exp_t e;
    e.isTrap = 1; e.tag = 0; e.role = 0; e.cls = 0; e.op = 0; e.req = req;
    expQ.push_back(e);
  endtask

  function automatic bit bad(input logic [14:0] s);
    return s[14:9] == 6'd63;
  endfunction
  function automatic bit tst(input logic [14:0] s);
    return (s[14:9] == 6'd61) || (s[14:9] == 6'd62);
  endfunction
  function automatic logic [14:0] sh(input logic [5:0] cls, input logic [8:0] low);
    return {cls, low};
  endfunction

  task automatic pushShort(input string req, input logic [1:0] tag, input logic [2:0] role, input logic [14:0] s);
    pushIss(req, tag, role, s[14:9], {15'd0, s});
  endtask

  task automatic checkCounters(input string req);
    chk("R8", {req, " cycle count"}, cycleCount, expCyc);
    chk("R4", {req, " skip count"}, skipCount, expSkip);
    chk("R5", {req, " true count"}, condTrueCount, expTrue);
    chk("R5", {req, " false count"}, condFalseCount, expFalse);
    chk("R10", {req, " saturating cycle count"}, sCyc, (expCyc > 7) ? 7 : expCyc);
  endtask

  task automatic runPacket(input string req, input logic [31:0] w, input bit pc, input bit cnd, input bit junk);
    logic [14:0] lft, rgt, first, second;
    logic [1:0] ftag;
    lft = w[29:15];
    rgt = w[14:0];
    respPc = pc;
    respCond = cnd;
    expCyc++;
    case (w[31:30])
      2'b00: if (w[29:24] == 6'd63) pushTrap(req); else pushIss(req, 2'd0, 3'd0, w[29:24], w[29:0]);
      2'b01, 2'b10: begin
        ftag   = (w[31:30] == 2'b01) ? 2'd2 : 2'd1;
        first  = (w[31:30] == 2'b01) ? rgt : lft;
        second = (w[31:30] == 2'b01) ? lft : rgt;
        if (bad(first)) pushTrap(req);
        else begin
          pushShort(req, ftag, 3'd1, first);
          if (pc) expSkip++;
          else if (bad(second)) pushTrap(req);
          else begin pushShort(req, 2'd3 - ftag, 3'd2, second); expCyc++; end
        end
      end
      default: begin
        if (bad(lft) || bad(rgt)) pushTrap(req);
        else if (tst(lft)) begin
          pushShort(req, 2'd1, 3'd5, lft);
          if (cnd) begin pushShort(req, 2'd2, 3'd6, rgt); expTrue++; end else expFalse++;
        end else if (tst(rgt)) begin
          pushShort(req, 2'd2, 3'd5, rgt);
          if (cnd) begin pushShort(req, 2'd1, 3'd6, lft); expTrue++; end else expFalse++;
        end else begin
          pushShort(req, 2'd1, 3'd3, lft);
          pushShort(req, 2'd2, 3'd4, rgt);
        end
      end
    endcase
    @(negedge clk);
    while (!wordReady) @(negedge clk);
    wordValid = 1'b1; wordIn = w;
    @(negedge clk);
    wordValid = 1'b0;
    if (junk) begin
      // R9: a long word offered while busy must not be taken
      wordValid = 1'b1; wordIn = {2'b00, 6'd7, 24'h00ABCD};
      @(negedge clk);
      wordValid = 1'b0;
    end
    while (!wordReady) @(negedge clk);
    @(negedge clk);
    chk(req, "all expected slots seen", expQ.size(), 0);
    checkCounters(req);
  endtask

  task automatic mainSeq();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset ready", wordReady, 1);
    chk("R10", "reset strobe", issueStrobe, 0);
    checkCounters("R10 reset");
    runPacket("R1",  {2'b00, 6'd5, 24'h123456}, 1, 0, 0);
    runPacket("R7",  {2'b00, 6'd63, 24'h000001}, 0, 0, 0);
    runPacket("R2",  {2'b01, sh(6'd9, 9'h011), sh(6'd20, 9'h1F0)}, 0, 0, 0);
    runPacket("R3",  {2'b10, sh(6'd33, 9'h055), sh(6'd2, 9'h0AA)}, 0, 0, 0);
    runPacket("R4",  {2'b10, sh(6'd12, 9'h001), sh(6'd13, 9'h002)}, 1, 0, 0);
    runPacket("R4",  {2'b01, sh(6'd14, 9'h003), sh(6'd15, 9'h004)}, 1, 0, 0);
    runPacket("R7",  {2'b01, sh(6'd4, 9'h0), sh(6'd63, 9'h1)}, 0, 0, 0);
    runPacket("R7",  {2'b10, sh(6'd4, 9'h7), sh(6'd63, 9'h8)}, 0, 0, 0);
    runPacket("R6",  {2'b11, sh(6'd1, 9'h100), sh(6'd60, 9'h0FF)}, 1, 0, 0);
    runPacket("R5",  {2'b11, sh(6'd62, 9'h021), sh(6'd3, 9'h042)}, 0, 1, 0);
    runPacket("R5",  {2'b11, sh(6'd8, 9'h021), sh(6'd61, 9'h042)}, 0, 0, 0);
    runPacket("R5",  {2'b11, sh(6'd61, 9'h111), sh(6'd62, 9'h122)}, 0, 1, 0);
    runPacket("R5",  {2'b11, sh(6'd10, 9'h033), sh(6'd62, 9'h044)}, 1, 1, 0);
    runPacket("R7",  {2'b11, sh(6'd62, 9'h0), sh(6'd63, 9'h0)}, 0, 1, 0);
    runPacket("R9",  {2'b10, sh(6'd16, 9'h0), sh(6'd17, 9'h0)}, 0, 0, 1);
    runPacket("R9",  {2'b00, 6'd44, 24'hFFFFFF}, 0, 0, 1);
    // R10: synchronous reset clears counters
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    expCyc = 0; expSkip = 0; expTrue = 0; expFalse = 0;
    @(negedge clk);
    checkCounters("R10 after reset");
    runPacket("R1",  {2'b00, 6'd0, 24'h000000}, 0, 0, 0);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule